// File: doc/BRIEF.md
# Multi-Bank External Memory Controller

This block sits between a 32-bit internal request port and an external bus of asynchronous memories such as ROM, flash or SRAM. The external space is split into four regions, each with its own active-low chip select and the full 24-bit external address. Software programs each region with a wait-state count (0 to 15) and a data-bus width of 8 or 16 bits. An internal byte, halfword or word access is cut into as many narrow external cycles as the selected region's bus needs. Read data is gathered into a little-endian 32-bit word, and completion is reported with a one-cycle pulse.

The sequencer is a five-state machine. IDLE accepts a request and goes to LEAD for a write or to STROBE for a read. LEAD drives write data for one cycle with the strobe still inactive, then moves to STROBE. STROBE holds the read or write strobe for 1 + W cycles. From STROBE the machine stays in STROBE to count wait states or to begin the next read part. It goes to TRAIL when a write strobe ends, and to DONE after the last read part. TRAIL holds write data for one cycle after the strobe and then goes to LEAD if write parts remain, or to DONE. DONE raises the completion pulse for one cycle and returns to IDLE.

A region's settings are copied when the request is accepted. A configuration write made during an access therefore first affects the next access.

Top module: `ext_mem_ctrl`

## Requirements
- R1: After reset, all four `mem_cs_n` bits are high, `mem_oe_n` and `mem_we_n` are high, `mem_doe` is low, `req_ready` is high, `rsp_done` is low and `rsp_rdata` is 0. Every region starts with 15 wait states and an 8-bit bus.
- R2: `req_addr[25:24]` = n selects region n. Only `mem_cs_n[n]` goes low, and it stays low without a gap from the first to the last external cycle of the access. All chip selects are high in the DONE cycle and while idle.
- R3: Each external strobe lasts 1 + W cycles, where W is the region's wait count. Count the cycle after the accepting clock edge as cycle 1. A read has `rsp_done` high in cycle P*(W+1)+1 and a write in cycle P*(W+3)+1, where P is the part count of R4.
- R4: `cfg_wide` = 0 selects an 8-bit bus and 1 selects a 16-bit bus. `req_size` 0 is a byte, 1 is a halfword, and 2 or 3 is a word. The part count P is the larger of 1 and (access bytes / bus bytes).
- R5: Part k drives `mem_addr` = `req_addr[23:0]` + k × (bus bytes). Requests are aligned to their own size.
- R6: On an 8-bit bus, read part k lands in byte k of `rsp_rdata`. On a 16-bit bus, halfword part k lands in bits [16k+15:16k]. A byte read on a 16-bit bus takes `mem_din[15:8]` for an odd address and `mem_din[7:0]` for an even one. Bits above the access width read as 0.
- R7: On an 8-bit bus, write part k puts byte k of `req_wdata` on `mem_dout[7:0]` with `mem_be_n` = 2'b10. On a 16-bit bus, a halfword or word write puts halfword k on `mem_dout` with `mem_be_n` = 2'b00. A byte write on a 16-bit bus puts `req_wdata[7:0]` on both lanes, with `mem_be_n` = 2'b10 for an even address and 2'b01 for an odd one.
- R8: `mem_doe` is high in the cycle before each falling edge of `mem_we_n` and in the cycle after each rising edge. `mem_oe_n` never goes low during a write, and `mem_we_n` never goes low during a read.
- R9: `rsp_done` is high for exactly one cycle, and `rsp_rdata` holds the result in that cycle. `req_ready` is high only while idle and is high again in the cycle after `rsp_done`.
- R10: A configuration write to a region that arrives during an access does not change that access's timing or width. It applies from the next access onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 2 | Region whose configuration is written |
| cfg_wait | input | 4 | Wait-state count to store |
| cfg_wide | input | 1 | Bus width to store: 0 = 8-bit, 1 = 16-bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; a request is accepted when valid and ready are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Byte address; bits [25:24] select the region |
| req_size | input | 2 | Access size: 0 = byte, 1 = halfword, 2 or 3 = word |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read data |
| mem_cs_n | output | 4 | Active-low chip selects, one per region |
| mem_addr | output | 24 | External byte address |
| mem_oe_n | output | 1 | Active-low output enable (read strobe) |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | 2 | Active-low byte-lane enables |
| mem_dout | output | 16 | Write data to the external bus |
| mem_doe | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | 16 | Read data from the external bus |

## Verification
The assertions assume that a request stays aligned to its own size, so the parts of a split access never leave the aligned word. They also assume that the memory settles `mem_din` combinationally from the address before the last strobe cycle ends. The stimulus produces only aligned addresses and size codes 0 to 3. The bench memory model answers combinationally from the current address. Configuration writes are injected mid-access only through the normal configuration port, so the frozen-settings property is tested against real traffic.

// File: rtl/emc_pkg.sv
package emc_pkg;
    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);
    localparam int XA_W   = 24;
    localparam int WAIT_W = 4;
    localparam int DW     = 32;
    localparam int XDW    = 16;
    localparam int PART_W = 2;

    typedef struct packed {
        logic [WAIT_W-1:0] waits;
        logic              wide;
    } bank_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_STROBE,
        ST_TRAIL,
        ST_DONE
    } emc_state_t;
endpackage

// File: rtl/emc_cfg_regs.sv
module emc_cfg_regs
    import emc_pkg::*;
#(
    parameter int NB = NBANK,
    parameter int BW = BANK_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [BW-1:0]          cfg_bank,
    input  logic [WAIT_W-1:0]      cfg_wait,
    input  logic                   cfg_wide,
    output bank_cfg_t [NB-1:0]     cfg_tab
);
    for (genvar g = 0; g < NB; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_tab[g].waits <= '1;
                cfg_tab[g].wide  <= 1'b0;
            end else if (cfg_we && cfg_bank == BW'(g)) begin
                cfg_tab[g].waits <= cfg_wait;
                cfg_tab[g].wide  <= cfg_wide;
            end
        end
    end
endmodule

// File: rtl/emc_seq.sv
module emc_seq
    import emc_pkg::*;
#(
    parameter int NB = NBANK,
    parameter int BW = BANK_W,
    parameter int AW = XA_W,
    parameter int PW = PART_W,
    parameter int W  = DW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [AW+BW-1:0]     req_addr,
    input  logic [1:0]           req_size,
    input  logic [W-1:0]         req_wdata,
    input  bank_cfg_t [NB-1:0]   cfg_tab,
    output logic                 req_ready,
    output logic                 rsp_done,
    output logic [NB-1:0]        mem_cs_n,
    output logic [AW-1:0]        mem_addr,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic                 mem_doe,
    output logic                 start,
    output logic                 capture,
    output logic [PW-1:0]        part,
    output logic                 cur_wide,
    output logic [1:0]           cur_size,
    output logic                 cur_addr0,
    output logic [W-1:0]         cur_wdata
);
    localparam int RA_W = AW + BW;

    emc_state_t        state_q, state_d;
    logic [BW-1:0]     bank_q;
    logic [AW-1:0]     base_q;
    logic [1:0]        sz_q;
    logic              wr_q;
    bank_cfg_t         cfg_q;
    logic [PW-1:0]     part_q, last_q;
    logic [WAIT_W-1:0] wcnt_q;
    logic [W-1:0]      wdata_q;

    logic [BW-1:0]     req_bank;
    logic [1:0]        sz_in;
    bank_cfg_t         cfg_in;
    logic [PW-1:0]     last_in;
    logic              accept, strobe_end, last_part;

    assign req_bank   = req_addr[RA_W-1 -: BW];
    assign sz_in      = (req_size == 2'd3) ? 2'd2 : req_size;
    assign cfg_in     = cfg_tab[req_bank];
    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign strobe_end = (wcnt_q == cfg_q.waits);
    assign last_part  = (part_q == last_q);

    always_comb begin
        if (sz_in == 2'd2 && !cfg_in.wide)
            last_in = PW'(3);
        else if (sz_in > {1'b0, cfg_in.wide})
            last_in = PW'(1);
        else
            last_in = '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = req_write ? ST_LEAD : ST_STROBE;
            ST_LEAD:   state_d = ST_STROBE;
            ST_STROBE: if (strobe_end) begin
                           if (wr_q)           state_d = ST_TRAIL;
                           else if (last_part) state_d = ST_DONE;
                           else                state_d = ST_STROBE;
                       end
            ST_TRAIL:  state_d = last_part ? ST_DONE : ST_LEAD;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q  <= '0;
            base_q  <= '0;
            sz_q    <= '0;
            wr_q    <= 1'b0;
            cfg_q   <= '0;
            last_q  <= '0;
            part_q  <= '0;
            wcnt_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            bank_q  <= req_bank;
            base_q  <= req_addr[AW-1:0];
            sz_q    <= sz_in;
            wr_q    <= req_write;
            cfg_q   <= cfg_in;
            last_q  <= last_in;
            part_q  <= '0;
            wcnt_q  <= '0;
            wdata_q <= req_wdata;
        end else if (state_q == ST_STROBE) begin
            if (strobe_end) begin
                wcnt_q <= '0;
                if (!wr_q && !last_part) part_q <= part_q + PW'(1);
            end else begin
                wcnt_q <= wcnt_q + WAIT_W'(1);
            end
        end else if (state_q == ST_TRAIL && !last_part) begin
            part_q <= part_q + PW'(1);
        end
    end

    always_comb begin
        logic active;
        active    = (state_q == ST_LEAD) || (state_q == ST_STROBE) || (state_q == ST_TRAIL);
        mem_cs_n  = '1;
        if (active) mem_cs_n[bank_q] = 1'b0;
        mem_addr  = base_q + (AW'(part_q) << cfg_q.wide);
        mem_oe_n  = !(state_q == ST_STROBE && !wr_q);
        mem_we_n  = !(state_q == ST_STROBE && wr_q);
        mem_doe   = wr_q && active;
        req_ready = (state_q == ST_IDLE);
        rsp_done  = (state_q == ST_DONE);
        start     = accept;
        capture   = (state_q == ST_STROBE) && !wr_q && strobe_end;
        part      = part_q;
        cur_wide  = cfg_q.wide;
        cur_size  = sz_q;
        cur_addr0 = base_q[0];
        cur_wdata = wdata_q;
    end

    p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));
    p_cs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n != '1) |=> (mem_cs_n == $past(mem_cs_n) || mem_cs_n == '1));
    p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE) |-> (wcnt_q <= cfg_q.waits));
    p_part_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (part_q <= last_q));
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    p_we_lead_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(mem_doe));
    p_we_trail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_doe);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));
    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n == '1));
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(cfg_q));
endmodule

// File: rtl/emc_lane_map.sv
module emc_lane_map
    import emc_pkg::*;
#(
    parameter int W  = DW,
    parameter int XW = XDW,
    parameter int PW = PART_W
) (
    input  logic [W-1:0]  wdata,
    input  logic          wide,
    input  logic [1:0]    size,
    input  logic          addr0,
    input  logic [PW-1:0] part,
    output logic [XW-1:0] dout,
    output logic [1:0]    be_n
);
    localparam int BYTE = 8;

    always_comb begin
        if (!wide) begin
            dout = {{(XW-BYTE){1'b0}}, wdata[{part, 3'b000} +: BYTE]};
            be_n = 2'b10;
        end else if (size == 2'd0) begin
            dout = {wdata[BYTE-1:0], wdata[BYTE-1:0]};
            be_n = addr0 ? 2'b01 : 2'b10;
        end else begin
            dout = wdata[{part[0], 4'b0000} +: XW];
            be_n = 2'b00;
        end
    end
endmodule

// File: rtl/emc_rd_asm.sv
module emc_rd_asm
    import emc_pkg::*;
#(
    parameter int W  = DW,
    parameter int XW = XDW,
    parameter int PW = PART_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          capture,
    input  logic [XW-1:0] din,
    input  logic          wide,
    input  logic [1:0]    size,
    input  logic          addr0,
    input  logic [PW-1:0] part,
    output logic [W-1:0]  rdata
);
    localparam int BYTE = 8;

    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            rdata <= '0;
        end else if (capture) begin
            if (!wide)
                rdata[{part, 3'b000} +: BYTE] <= din[BYTE-1:0];
            else if (size == 2'd0)
                rdata[BYTE-1:0] <= addr0 ? din[XW-1 -: BYTE] : din[BYTE-1:0];
            else
                rdata[{part[0], 4'b0000} +: XW] <= din;
        end
    end
endmodule

// File: rtl/ext_mem_ctrl.sv
module ext_mem_ctrl
    import emc_pkg::*;
#(
    parameter int NB = NBANK,
    parameter int BW = BANK_W,
    parameter int AW = XA_W,
    parameter int W  = DW,
    parameter int XW = XDW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BW-1:0]     cfg_bank,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_wide,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW+BW-1:0]  req_addr,
    input  logic [1:0]        req_size,
    input  logic [W-1:0]      req_wdata,
    output logic              rsp_done,
    output logic [W-1:0]      rsp_rdata,
    output logic [NB-1:0]     mem_cs_n,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [1:0]        mem_be_n,
    output logic [XW-1:0]     mem_dout,
    output logic              mem_doe,
    input  logic [XW-1:0]     mem_din
);
    bank_cfg_t [NB-1:0] cfg_tab;
    logic               start, capture, cur_wide, cur_addr0;
    logic [PART_W-1:0]  part;
    logic [1:0]         cur_size;
    logic [W-1:0]       cur_wdata;

    emc_cfg_regs #(.NB(NB), .BW(BW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_wait(cfg_wait), .cfg_wide(cfg_wide), .cfg_tab(cfg_tab)
    );

    emc_seq #(.NB(NB), .BW(BW), .AW(AW), .PW(PART_W), .W(W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .cfg_tab(cfg_tab), .req_ready(req_ready), .rsp_done(rsp_done),
        .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_doe(mem_doe), .start(start), .capture(capture),
        .part(part), .cur_wide(cur_wide), .cur_size(cur_size),
        .cur_addr0(cur_addr0), .cur_wdata(cur_wdata)
    );

    emc_lane_map #(.W(W), .XW(XW), .PW(PART_W)) u_lane (
        .wdata(cur_wdata), .wide(cur_wide), .size(cur_size), .addr0(cur_addr0),
        .part(part), .dout(mem_dout), .be_n(mem_be_n)
    );

    emc_rd_asm #(.W(W), .XW(XW), .PW(PART_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .start(start), .capture(capture), .din(mem_din),
        .wide(cur_wide), .size(cur_size), .addr0(cur_addr0), .part(part),
        .rdata(rsp_rdata)
    );
endmodule

// File: tb/tb_ext_mem_ctrl.sv
`timescale 1ns/1ps
module tb_ext_mem_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_bank = '0;
    logic [3:0]  cfg_wait = '0;
    logic        cfg_wide = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [25:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic [3:0]  mem_cs_n;
    logic [23:0] mem_addr;
    logic        mem_oe_n, mem_we_n, mem_doe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dout;
    logic [15:0] mem_din;

    always #2.5 clk = ~clk;

    ext_mem_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_wait(cfg_wait), .cfg_wide(cfg_wide), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_be_n(mem_be_n),
        .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din)
    );

    logic [7:0] ref_mem [0:1023];
    logic [7:0] bus_mem [0:1023];
    int         ref_wait [4];
    bit         ref_wide [4];
    logic [1:0] acc_bank = '0;
    bit         acc_wide = 1'b0;
    int         n_chk = 0;
    int         n_fail = 0;

    always_comb begin
        if (acc_wide)
            mem_din = {bus_mem[{acc_bank, mem_addr[7:1], 1'b1}],
                       bus_mem[{acc_bank, mem_addr[7:1], 1'b0}]};
        else
            mem_din = {8'h00, bus_mem[{acc_bank, mem_addr[7:0]}]};
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic set_cfg(input logic [1:0] b, input logic [3:0] w, input bit wd);
        @(negedge clk);
        cfg_we = 1'b1; cfg_bank = b; cfg_wait = w; cfg_wide = wd;
        @(negedge clk);
        cfg_we = 1'b0;
        ref_wait[b] = int'(w);
        ref_wide[b] = wd;
    endtask

    task automatic access(input bit wr, input logic [25:0] addr, input logic [1:0] size,
                          input logic [31:0] wd, input bit inj, input logic [3:0] inj_w,
                          input bit inj_wd, output int lat);
        logic [1:0]  bank;
        logic [3:0]  exp_cs;
        logic [9:0]  base;
        logic [31:0] exp_d;
        int w, bytes, bb, parts, exp_n, n, cs_err, ad_err, dir_err, mm;
        bit pwe, pdoe;
        bank   = addr[25:24];
        w      = ref_wait[bank];
        bytes  = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
        bb     = ref_wide[bank] ? 2 : 1;
        parts  = (bytes > bb) ? bytes / bb : 1;
        exp_n  = wr ? parts * (w + 3) + 1 : parts * (w + 1) + 1;
        acc_bank = bank;
        acc_wide = ref_wide[bank];
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = size; req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 1'b0;
        n = 0; pwe = 1'b1; pdoe = 1'b0; cs_err = 0; ad_err = 0; dir_err = 0;
        do begin
            @(negedge clk);
            n++;
            if (inj && n == 2) begin
                cfg_we = 1'b1; cfg_bank = bank; cfg_wait = inj_w; cfg_wide = inj_wd;
            end
            if (n == 3) cfg_we = 1'b0;
            exp_cs = rsp_done ? 4'hF : ~(4'b0001 << bank);
            if (mem_cs_n != exp_cs) cs_err++;
            if (!rsp_done && mem_addr[23:2] != addr[23:2]) ad_err++;
            if (wr ? !mem_oe_n : !mem_we_n) dir_err++;
            if (!mem_we_n && pwe && !pdoe) dir_err++;
            if (mem_we_n && !pwe && !mem_doe) dir_err++;
            if (!mem_we_n) begin
                if (!acc_wide) begin
                    if (!mem_be_n[0]) bus_mem[{bank, mem_addr[7:0]}] = mem_dout[7:0];
                end else begin
                    if (!mem_be_n[0]) bus_mem[{bank, mem_addr[7:1], 1'b0}] = mem_dout[7:0];
                    if (!mem_be_n[1]) bus_mem[{bank, mem_addr[7:1], 1'b1}] = mem_dout[15:8];
                end
            end
            pwe = mem_we_n; pdoe = mem_doe;
        end while (!rsp_done && n < 400);
        lat = n;
        check(n == exp_n, "R3", "latency in cycles (parts per R4)", n, exp_n);
        check(cs_err == 0, "R2", "chip-select mismatches", cs_err, 0);
        check(ad_err == 0, "R5", "address outside aligned word", ad_err, 0);
        check(dir_err == 0, "R8", "strobe or data-drive violations", dir_err, 0);
        base = {bank, addr[7:0]};
        if (wr) begin
            for (int k = 0; k < bytes; k++) ref_mem[10'(base + k)] = wd[8*k +: 8];
            mm = 0;
            for (int k = 0; k < 4; k++)
                if (bus_mem[{bank, addr[7:2], 2'(k)}] != ref_mem[{bank, addr[7:2], 2'(k)}]) mm++;
            check(mm == 0, "R7", "written bytes differing from model", mm, 0);
        end else begin
            exp_d = '0;
            for (int k = 0; k < bytes; k++) exp_d[8*k +: 8] = ref_mem[10'(base + k)];
            check(rsp_rdata == exp_d, "R6", "read data", rsp_rdata, exp_d);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check(!rsp_done && req_ready && mem_cs_n == 4'hF, "R9", "done pulse width / ready",
              {rsp_done, req_ready, mem_cs_n}, {1'b0, 1'b1, 4'hF});
        if (inj) begin
            ref_wait[bank] = int'(inj_w);
            ref_wide[bank] = inj_wd;
        end
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog R9: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int lat;
        logic [1:0]  b, sz;
        logic [7:0]  lo;
        logic [15:0] hi;
        int bytes;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 1024; i++) begin
            ref_mem[i] = 8'(i * 37 + 11);
            bus_mem[i] = 8'(i * 37 + 11);
        end
        for (int i = 0; i < 4; i++) begin ref_wait[i] = 15; ref_wide[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n == 4'hF && mem_oe_n && mem_we_n && !mem_doe, "R1", "bus idle after reset",
              {mem_cs_n, mem_oe_n, mem_we_n, mem_doe}, {4'hF, 1'b1, 1'b1, 1'b0});
        check(req_ready && !rsp_done && rsp_rdata == 32'h0, "R1", "port state after reset",
              {req_ready, rsp_done, rsp_rdata}, {1'b1, 1'b0, 32'h0});

        access(1'b0, 26'h0000010, 2'd2, 32'h0, 1'b0, 4'd0, 1'b0, lat);
        check(lat == 65, "R1", "default region timing (15 waits, 8-bit)", lat, 65);

        set_cfg(2'd1, 4'd0, 1'b1);
        set_cfg(2'd2, 4'd3, 1'b0);
        set_cfg(2'd3, 4'd7, 1'b1);
        set_cfg(2'd0, 4'd1, 1'b0);

        access(1'b1, 26'h1ABCD40, 2'd2, 32'hA1B2C3D4, 1'b0, 4'd0, 1'b0, lat);
        access(1'b0, 26'h1ABCD40, 2'd2, 32'h0, 1'b0, 4'd0, 1'b0, lat);
        access(1'b1, 26'h1000021, 2'd0, 32'h000000E7, 1'b0, 4'd0, 1'b0, lat);
        access(1'b0, 26'h1000021, 2'd0, 32'h0, 1'b0, 4'd0, 1'b0, lat);
        access(1'b0, 26'h1000020, 2'd0, 32'h0, 1'b0, 4'd0, 1'b0, lat);
        access(1'b1, 26'h2123402, 2'd1, 32'h00005A6B, 1'b0, 4'd0, 1'b0, lat);
        access(1'b0, 26'h2123400, 2'd3, 32'h0, 1'b0, 4'd0, 1'b0, lat);
        access(1'b1, 26'h3FFFFFC, 2'd2, 32'h13579BDF, 1'b0, 4'd0, 1'b0, lat);
        access(1'b0, 26'h3FFFFFE, 2'd1, 32'h0, 1'b0, 4'd0, 1'b0, lat);

        access(1'b0, 26'h2000080, 2'd2, 32'h0, 1'b1, 4'd0, 1'b1, lat);
        check(lat == 17, "R10", "mid-access config must not alter current access", lat, 17);
        access(1'b0, 26'h2000084, 2'd2, 32'h0, 1'b0, 4'd0, 1'b0, lat);
        check(lat == 3, "R10", "new config applies to next access", lat, 3);

        for (int it = 0; it < 120; it++) begin
            if ($urandom % 8 == 0)
                set_cfg(2'($urandom), 4'($urandom), 1'($urandom));
            b  = 2'($urandom);
            sz = 2'($urandom);
            bytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
            lo = 8'($urandom) & ~8'(bytes - 1);
            hi = 16'($urandom);
            access(1'($urandom), {b, hi, lo}, sz, $urandom, ($urandom % 6 == 0),
                   4'($urandom), 1'($urandom), lat);
        end

        summary();
        $finish;
    end
endmodule